// File: doc/BRIEF.md
# FIFO DMA Request Handshake

This block produces the two request lines that an external DMA controller watches: one for a receive FIFO that has data waiting, and one for a transmit FIFO that has room. It also takes two active-low acknowledge lines. While an acknowledge is low, a bus access of the matching direction goes straight to its FIFO. The address and chip-select decode are ignored for that access. The FIFO storage stays outside the block. Each FIFO reports its fill level on an input. A one-cycle start pulse marks the first cycle of every bus strobe.

A request is withdrawn at the start of the access that will empty the receive FIFO or fill the transmit FIFO. It does not wait for that access to finish, so the DMA controller never begins a transfer that the FIFO cannot serve. After such an early withdrawal the request stays low until the strobe ends, and it rises again only when the reported level allows another transfer. An acknowledged read on an empty receive FIFO, or an acknowledged write on a full transmit FIFO, moves no data. It sets a sticky error flag instead.

Top module: `fifo_dma_handshake`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, every output is 0.
- R2: With no early withdrawal in force, `rx_dreq` in the cycle after a clock edge is 1 exactly when `rx_level` was nonzero at that edge.
- R3: A read start that hits the receive FIFO while `rx_level` is 1 drives `rx_dreq` to 0 in the following cycle. `rx_dreq` then stays 0 for as long as `bus_rd` stays high, whatever the level.
- R4: With no early withdrawal in force, `tx_dreq` in the cycle after a clock edge is 1 exactly when `tx_level` was below DEPTH at that edge.
- R5: A write start that hits the transmit FIFO while `tx_level` is DEPTH-1 drives `tx_dreq` to 0 in the following cycle. `tx_dreq` then stays 0 for as long as `bus_wr` stays high.
- R6: When `bus_start` and `bus_rd` are high, `rx_ack_n` is 0 and `rx_level` is nonzero, `rx_pop` pulses for one cycle in the next cycle, whatever the values of `addr` and `cs_ok`.
- R7: When `bus_start` and `bus_wr` are high, `tx_ack_n` is 0 and `tx_level` is below DEPTH, `tx_push` pulses in the next cycle, whatever the values of `addr` and `cs_ok`.
- R8: When its acknowledge is high, an access reaches a FIFO only with `cs_ok` at 1 and `addr` equal to RX_ADDR (default 0x10) for a read or TX_ADDR (default 0x11) for a write. Any other access produces no pulse.
- R9: An acknowledged read start with `rx_level` at 0 produces no `rx_pop` and sets `rx_err`. `rx_err` then stays 1 until reset.
- R10: An acknowledged write start with `tx_level` at DEPTH produces no `tx_push` and sets `tx_err`. `tx_err` then stays 1 until reset.
- R11: After an early withdrawal, a request rises again in the cycle after the first edge at which its strobe is low and the level allows a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_level | input | CNT_W | Words held in the receive FIFO |
| tx_level | input | CNT_W | Words held in the transmit FIFO |
| bus_rd | input | 1 | Read strobe, level, active high |
| bus_wr | input | 1 | Write strobe, level, active high |
| bus_start | input | 1 | First cycle of a strobe |
| cs_ok | input | 1 | Chip selects decoded as valid |
| addr | input | ADDR_W | Register address of the access |
| rx_ack_n | input | 1 | Receive acknowledge, active low |
| tx_ack_n | input | 1 | Transmit acknowledge, active low |
| rx_dreq | output | 1 | Receive DMA request |
| tx_dreq | output | 1 | Transmit DMA request |
| rx_pop | output | 1 | Pop pulse to the receive FIFO |
| tx_push | output | 1 | Push pulse to the transmit FIFO |
| rx_err | output | 1 | Sticky underrun flag |
| tx_err | output | 1 | Sticky overrun flag |

## Verification
A corrupted hold state shows as a request that is wrong in the very next cycle. Either it stays low after the strobe has dropped, or it stays high after a last-word start. Every output is one register away from its inputs, so any decode or level fault appears one cycle after the edge that caused it. A lost sticky bit shows as an error flag falling with no reset. The random traffic favours levels of 0, 1, DEPTH-1 and DEPTH, because those are the levels where every one of these faults becomes visible.

// File: rtl/dmahs_pkg.sv
package dmahs_pkg;

    // Result of access steering for one channel
    typedef struct packed {
        logic hit;      // access is routed to this FIFO
        logic acked;    // routing came from the acknowledge line
    } steer_t;

    // Early-withdrawal hold state of one request line
    typedef enum logic {
        CH_OPEN = 1'b0,
        CH_HELD = 1'b1
    } hold_e;

    // Registered outputs of one channel
    typedef struct packed {
        logic dreq;
        logic xfer;
        logic err;
    } chan_out_t;

    // A transfer is possible at this level
    function automatic logic lvl_avail(input bit is_tx, input int unsigned cnt,
                                       input int unsigned depth);
        return is_tx ? (cnt < depth) : (cnt != 0);
    endfunction

    // The coming transfer is the one that empties or fills the FIFO
    function automatic logic lvl_last(input bit is_tx, input int unsigned cnt,
                                      input int unsigned depth);
        return is_tx ? (cnt == depth - 1) : (cnt == 1);
    endfunction

endpackage

// File: rtl/dmahs_steer.sv
module dmahs_steer
    import dmahs_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int RX_ADDR = 16,
    parameter int TX_ADDR = 17
) (
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic              cs_ok,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rx_ack_n,
    input  logic              tx_ack_n,
    output steer_t            rx_st,
    output steer_t            tx_st
);
    localparam logic [ADDR_W-1:0] RX_A = ADDR_W'(RX_ADDR);
    localparam logic [ADDR_W-1:0] TX_A = ADDR_W'(TX_ADDR);

    logic rx_dec, tx_dec;

    always_comb begin
        rx_dec      = cs_ok && (addr == RX_A);
        tx_dec      = cs_ok && (addr == TX_A);
        // acknowledge takes precedence and bypasses decode entirely
        rx_st.acked = bus_rd && !rx_ack_n;
        tx_st.acked = bus_wr && !tx_ack_n;
        rx_st.hit   = rx_st.acked || (bus_rd && rx_dec);
        tx_st.hit   = tx_st.acked || (bus_wr && tx_dec);
    end
endmodule

// File: rtl/dmahs_chan.sv
module dmahs_chan
    import dmahs_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5,
    parameter bit IS_TX = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] level,
    input  logic             strobe,
    input  logic             bus_start,
    input  steer_t           st,
    output chan_out_t        q
);
    hold_e     hold_q, hold_d;
    chan_out_t q_d;
    logic      avail, last, go;

    always_comb begin
        avail = lvl_avail(IS_TX, 32'(level), DEPTH);
        last  = lvl_last(IS_TX, 32'(level), DEPTH);
        go    = bus_start && st.hit;

        // hold the request low from the start of the final transfer
        // until its strobe is released
        if ((go && last) || (hold_q == CH_HELD && strobe))
            hold_d = CH_HELD;
        else
            hold_d = CH_OPEN;

        q_d.dreq = avail && (hold_d == CH_OPEN);
        q_d.xfer = go && avail;
        q_d.err  = q.err || (bus_start && st.acked && !avail);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= CH_OPEN;
            q      <= '0;
        end else begin
            hold_q <= hold_d;
            q      <= q_d;
        end
    end
endmodule

// File: rtl/fifo_dma_handshake.sv
module fifo_dma_handshake
    import dmahs_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int ADDR_W  = 6,
    parameter int RX_ADDR = 16,
    parameter int TX_ADDR = 17,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  rx_level,
    input  logic [CNT_W-1:0]  tx_level,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic              bus_start,
    input  logic              cs_ok,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rx_ack_n,
    input  logic              tx_ack_n,
    output logic              rx_dreq,
    output logic              tx_dreq,
    output logic              rx_pop,
    output logic              tx_push,
    output logic              rx_err,
    output logic              tx_err
);
    steer_t    st   [2];
    chan_out_t cq   [2];
    logic [CNT_W-1:0] lvl [2];
    logic      strb [2];

    assign lvl[0]  = rx_level;
    assign lvl[1]  = tx_level;
    assign strb[0] = bus_rd;
    assign strb[1] = bus_wr;

    dmahs_steer #(
        .ADDR_W (ADDR_W),
        .RX_ADDR(RX_ADDR),
        .TX_ADDR(TX_ADDR)
    ) u_steer (
        .bus_rd  (bus_rd),
        .bus_wr  (bus_wr),
        .cs_ok   (cs_ok),
        .addr    (addr),
        .rx_ack_n(rx_ack_n),
        .tx_ack_n(tx_ack_n),
        .rx_st   (st[0]),
        .tx_st   (st[1])
    );

    for (genvar c = 0; c < 2; c++) begin : g_chan
        dmahs_chan #(
            .DEPTH(DEPTH),
            .CNT_W(CNT_W),
            .IS_TX(c == 1)
        ) u_chan (
            .clk      (clk),
            .rst      (rst),
            .level    (lvl[c]),
            .strobe   (strb[c]),
            .bus_start(bus_start),
            .st       (st[c]),
            .q        (cq[c])
        );
    end

    assign rx_dreq = cq[0].dreq;
    assign rx_pop  = cq[0].xfer;
    assign rx_err  = cq[0].err;
    assign tx_dreq = cq[1].dreq;
    assign tx_push = cq[1].xfer;
    assign tx_err  = cq[1].err;
endmodule

// File: rtl/fifo_dma_handshake_chk.sv
module fifo_dma_handshake_chk #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] rx_level,
    input logic [CNT_W-1:0] tx_level,
    input logic             bus_rd,
    input logic             bus_wr,
    input logic             bus_start,
    input logic             rx_ack_n,
    input logic             tx_ack_n,
    input logic             rx_dreq,
    input logic             tx_dreq,
    input logic             rx_pop,
    input logic             tx_push,
    input logic             rx_err,
    input logic             tx_err
);
    p_rx_req_needs_data_r2: assert property (@(posedge clk) disable iff (rst)
        rx_dreq |-> ($past(rx_level) != 0));

    p_tx_req_needs_room_r4: assert property (@(posedge clk) disable iff (rst)
        tx_dreq |-> (int'($past(tx_level)) < DEPTH));

    p_rx_early_drop_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_start && bus_rd && !rx_ack_n && rx_level == 1) |=> !rx_dreq);

    p_tx_early_drop_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_start && bus_wr && !tx_ack_n && int'(tx_level) == DEPTH - 1) |=> !tx_dreq);

    p_ack_pop_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_start && bus_rd && !rx_ack_n && rx_level != 0) |=> rx_pop);

    p_ack_push_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_start && bus_wr && !tx_ack_n && int'(tx_level) < DEPTH) |=> tx_push);

    p_no_pop_empty_r9: assert property (@(posedge clk) disable iff (rst)
        rx_pop |-> ($past(rx_level) != 0));

    p_no_push_full_r10: assert property (@(posedge clk) disable iff (rst)
        tx_push |-> (int'($past(tx_level)) < DEPTH));

    p_rx_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        rx_err |=> rx_err);

    p_tx_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        tx_err |=> tx_err);
endmodule

bind fifo_dma_handshake fifo_dma_handshake_chk #(
    .DEPTH(DEPTH),
    .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/fifo_dma_handshake_tb.sv
module fifo_dma_handshake_tb;
    localparam int DEPTH   = 16;
    localparam int ADDR_W  = 6;
    localparam int RX_ADDR = 16;
    localparam int TX_ADDR = 17;
    localparam int CNT_W   = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst;
    logic [CNT_W-1:0]  rx_level, tx_level;
    logic bus_rd, bus_wr, bus_start, cs_ok, rx_ack_n, tx_ack_n;
    logic [ADDR_W-1:0] addr;
    logic rx_dreq, tx_dreq, rx_pop, tx_push, rx_err, tx_err;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    // reference state and expectations
    bit m_rx_hold, m_tx_hold, m_rx_err, m_tx_err;
    bit e_rx_dreq, e_tx_dreq, e_rx_pop, e_tx_push;

    always #10 clk = ~clk;

    fifo_dma_handshake #(
        .DEPTH(DEPTH), .ADDR_W(ADDR_W), .RX_ADDR(RX_ADDR), .TX_ADDR(TX_ADDR)
    ) u_dut (
        .clk(clk), .rst(rst), .rx_level(rx_level), .tx_level(tx_level),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_start(bus_start), .cs_ok(cs_ok),
        .addr(addr), .rx_ack_n(rx_ack_n), .tx_ack_n(tx_ack_n),
        .rx_dreq(rx_dreq), .tx_dreq(tx_dreq), .rx_pop(rx_pop), .tx_push(tx_push),
        .rx_err(rx_err), .tx_err(tx_err)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    // expected outputs for the next cycle, derived from the requirements
    task automatic predict();
        bit rx_hit, tx_hit, rx_ackd, tx_ackd, rx_av, tx_av, rx_last, tx_last, nh;
        rx_ackd = bus_rd && !rx_ack_n;
        tx_ackd = bus_wr && !tx_ack_n;
        rx_hit  = rx_ackd || (bus_rd && cs_ok && addr == ADDR_W'(RX_ADDR));
        tx_hit  = tx_ackd || (bus_wr && cs_ok && addr == ADDR_W'(TX_ADDR));
        rx_av   = rx_level != 0;
        rx_last = rx_level == 1;
        tx_av   = int'(tx_level) < DEPTH;
        tx_last = int'(tx_level) == DEPTH - 1;

        nh        = (bus_start && rx_hit && rx_last) || (m_rx_hold && bus_rd);
        e_rx_dreq = rx_av && !nh;
        e_rx_pop  = bus_start && rx_hit && rx_av;
        m_rx_err  = m_rx_err || (bus_start && rx_ackd && !rx_av);
        m_rx_hold = nh;

        nh        = (bus_start && tx_hit && tx_last) || (m_tx_hold && bus_wr);
        e_tx_dreq = tx_av && !nh;
        e_tx_push = bus_start && tx_hit && tx_av;
        m_tx_err  = m_tx_err || (bus_start && tx_ackd && !tx_av);
        m_tx_hold = nh;
    endtask

    // called right after inputs are driven at a falling edge
    task automatic cycle();
        predict();
        @(posedge clk);
        @(negedge clk);
        chk("R2",  "rx_dreq", rx_dreq, e_rx_dreq);
        chk("R4",  "tx_dreq", tx_dreq, e_tx_dreq);
        chk("R6",  "rx_pop",  rx_pop,  e_rx_pop);
        chk("R7",  "tx_push", tx_push, e_tx_push);
        chk("R9",  "rx_err",  rx_err,  m_rx_err);
        chk("R10", "tx_err",  tx_err,  m_tx_err);
    endtask

    task automatic idle_in();
        bus_rd = 0; bus_wr = 0; bus_start = 0; cs_ok = 0; addr = '0;
        rx_ack_n = 1; tx_ack_n = 1;
    endtask

    task automatic do_reset();
        rst = 1; idle_in(); rx_level = '0; tx_level = '0;
        repeat (2) @(negedge clk);
        chk("R1", "rx_dreq", rx_dreq, 1'b0);
        chk("R1", "tx_dreq", tx_dreq, 1'b0);
        chk("R1", "rx_err",  rx_err,  1'b0);
        chk("R1", "tx_err",  tx_err,  1'b0);
        m_rx_hold = 0; m_tx_hold = 0; m_rx_err = 0; m_tx_err = 0;
        rst = 0;
        cycle();
        chk("R1", "rx_pop",  rx_pop,  1'b0);
        chk("R1", "tx_push", tx_push, 1'b0);
    endtask

    function automatic logic [CNT_W-1:0] rand_level();
        case ($urandom_range(0, 5))
            0: return CNT_W'(0);
            1: return CNT_W'(1);
            2: return CNT_W'(DEPTH - 1);
            3: return CNT_W'(DEPTH);
            default: return CNT_W'($urandom_range(0, DEPTH));
        endcase
    endfunction

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();

        // R3 / R11: last receive word
        rx_level = 1; cycle();
        chk("R2", "rx_dreq one word", rx_dreq, 1'b1);
        bus_rd = 1; bus_start = 1; rx_ack_n = 0; addr = 6'h3f; cycle();
        chk("R3", "rx_dreq at last read", rx_dreq, 1'b0);
        chk("R6", "rx_pop ack any addr", rx_pop, 1'b1);
        bus_start = 0; cycle();
        chk("R3", "rx_dreq held during strobe", rx_dreq, 1'b0);
        rx_level = 3; cycle();
        chk("R11", "rx_dreq held despite level", rx_dreq, 1'b0);
        idle_in(); cycle();
        chk("R11", "rx_dreq back after strobe", rx_dreq, 1'b1);

        // R5 / R11: last transmit slot
        tx_level = CNT_W'(DEPTH - 1); cycle();
        chk("R4", "tx_dreq one slot", tx_dreq, 1'b1);
        bus_wr = 1; bus_start = 1; tx_ack_n = 0; cs_ok = 0; cycle();
        chk("R5", "tx_dreq at last write", tx_dreq, 1'b0);
        chk("R7", "tx_push ack no cs", tx_push, 1'b1);
        bus_start = 0; tx_level = 2; cycle();
        chk("R5", "tx_dreq held during strobe", tx_dreq, 1'b0);
        idle_in(); cycle();
        chk("R11", "tx_dreq back after strobe", tx_dreq, 1'b1);

        // R8: decoded access without acknowledge
        rx_level = 5;
        bus_rd = 1; bus_start = 1; cs_ok = 1; addr = ADDR_W'(RX_ADDR); cycle();
        chk("R8", "rx_pop decoded", rx_pop, 1'b1);
        idle_in(); bus_rd = 1; bus_start = 1; cs_ok = 1; addr = ADDR_W'(RX_ADDR + 2); cycle();
        chk("R8", "rx_pop wrong addr", rx_pop, 1'b0);
        idle_in(); bus_rd = 1; bus_start = 1; cs_ok = 0; addr = ADDR_W'(RX_ADDR); cycle();
        chk("R8", "rx_pop no cs", rx_pop, 1'b0);
        idle_in(); bus_wr = 1; bus_start = 1; cs_ok = 1; addr = ADDR_W'(RX_ADDR); cycle();
        chk("R8", "tx_push rx addr", tx_push, 1'b0);
        idle_in(); bus_wr = 1; bus_start = 1; cs_ok = 1; addr = ADDR_W'(TX_ADDR); cycle();
        chk("R8", "tx_push decoded", tx_push, 1'b1);
        idle_in(); cycle();

        // constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            int op;
            op        = $urandom_range(0, 2);
            bus_rd    = (op == 1);
            bus_wr    = (op == 2);
            bus_start = $urandom_range(0, 1);
            cs_ok     = $urandom_range(0, 1);
            addr      = ($urandom_range(0, 1) == 1) ? ADDR_W'(RX_ADDR + $urandom_range(0, 1))
                                                    : ADDR_W'($urandom);
            rx_ack_n  = $urandom_range(0, 2) != 0;
            tx_ack_n  = $urandom_range(0, 2) != 0;
            rx_level  = rand_level();
            tx_level  = rand_level();
            cycle();
        end

        // R9 / R10: acknowledged access with no data or no room
        idle_in(); do_reset();
        rx_level = 0; bus_rd = 1; bus_start = 1; rx_ack_n = 0; cycle();
        chk("R9", "rx_pop on empty", rx_pop, 1'b0);
        chk("R9", "rx_err set", rx_err, 1'b1);
        idle_in(); rx_level = 4; cycle(); cycle();
        chk("R9", "rx_err sticky", rx_err, 1'b1);
        tx_level = CNT_W'(DEPTH); bus_wr = 1; bus_start = 1; tx_ack_n = 0; cycle();
        chk("R10", "tx_push on full", tx_push, 1'b0);
        chk("R10", "tx_err set", tx_err, 1'b1);
        idle_in(); tx_level = 0; cycle(); cycle();
        chk("R10", "tx_err sticky", tx_err, 1'b1);
        do_reset();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule